// File: doc/BRIEF.md
# UART task/event control block

This block is the register-facing control logic of a small UART. Software drives it through write-one "task" registers that start and stop the transmitter and receiver, and it reads status from latched "event" registers. Each event has its own bit in an interrupt mask, and the masked events are ORed into one interrupt line. A byte written to the transmit-data register is handed to an external shift engine over a valid/ready handshake. A break detector and the receive buffer report to the block through single-cycle pulse inputs.

The bus is a single-cycle word-addressed port. A write takes effect on the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`. Word address map: 0 start-RX, 1 stop-RX, 2 start-TX, 3 stop-TX, 4 suspend, 5 RX-ready event, 6 TX-ready event, 7 error event, 8 RX-timeout event, 9 mask (direct), 10 mask set, 11 mask clear, 12 error source, 13 enable, 14..17 pin selects 0..3, 18 baud, 19 TX data.

Top module: `uart_taskevt_ctrl`

## Requirements
- R1: After reset the four pin-select words (addresses 14..17) read 0xFFFFFFFF, the baud word (18) reads 0x04000000, and the mask, events, error source and TX data read 0 once the block is enabled. `irq`, `tx_valid` and `rx_run` are 0.
- R2: Writing exactly 4 to address 13 enables the block and writing 0 disables it. Any other value leaves the enable state unchanged. Address 13 reads 4 while the block is enabled.
- R3: While the block is disabled, every read returns 0 and every write to an address other than 13 has no effect.
- R4: Writing 0 to address 13 also stops the transmitter and the receiver and sets the RX-timeout event. This happens even when the block is already disabled.
- R5: A write to start-RX (0) or start-TX (2) takes effect only when the value is exactly 1. `rx_run` shows the receiver-started state.
- R6: Writing 1 to stop-TX (3) clears only the TX-started state. Writing 1 to stop-RX (1) clears RX-started and sets the RX-timeout event. Writing 1 to suspend (4) does both. Other values have no effect.
- R7: A write to TX data (19) is accepted only while TX is started and no byte is pending. An accepted byte drives `tx_data` with `tx_valid` high until a cycle with `tx_ready` high. It then clears `tx_valid` and sets the TX-ready event. Address 19 reads back the last accepted byte.
- R8: Events read as bit 0 of their word. Writing 0 to the RX-ready event (5) clears it and nonzero writes are ignored. The TX-ready (6), error (7) and RX-timeout (8) events take "value is nonzero" on a write. A hardware set in the same cycle wins over a write. A `rx_got` pulse sets RX-ready.
- R9: Mask bit 0 gates RX-ready, bit 1 TX-ready, bit 2 error and bit 3 RX-timeout. Address 9 loads the mask, 10 ORs bits in and 11 clears the bits written as 1. Reading any of the three returns the mask.
- R10: `irq` is high exactly when some event is set while its mask bit is set. This holds whether or not the block is enabled.
- R11: The error source (12, two bits) is write-one-to-clear. A `line_brk` pulse ORs 3 into it and sets the error event, and wins over a same-cycle clear.
- R12: The task addresses 0..4 and unmapped addresses read 0. Writes to unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tx_valid | output | 1 | A byte is pending for the shift engine |
| tx_data | output | 8 | Pending byte |
| tx_ready | input | 1 | Shift engine takes the byte |
| rx_got | input | 1 | Receive buffer pulse: a byte arrived |
| line_brk | input | 1 | Break detector pulse |
| rx_run | output | 1 | Receiver is started |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the points where two sources meet in one cycle.

- A hardware set and a software clear of the same event land together. A design that lets the write win loses an RX-ready or a break.
- A TXD write arrives while a byte is still pending. A design that accepts it corrupts `tx_data` mid-handshake.
- The magic enable value is exercised with near misses such as 5 and 1. A design that tests for nonzero would enable on these.
- Disable is checked for its side effects. A design that treats it as a plain flag leaves the receiver running and never raises the RX-timeout event.
- Long random write streams are compared against a behavioural model on every cycle. These expose alias mix-ups in the mask and wrong write semantics on the event words.

// File: rtl/uart_te_pkg.sv
package uart_te_pkg;
  localparam int AW     = 5;
  localparam int DW     = 32;
  localparam int NEV    = 4;
  localparam int NPIN   = 4;
  localparam int BYTE_W = 8;
  localparam int ESRC_W = 2;

  // event bit positions, shared by the event file and the mask
  localparam int EV_RXRDY = 0;
  localparam int EV_TXRDY = 1;
  localparam int EV_ERR   = 2;
  localparam int EV_RXTO  = 3;

  localparam logic [DW-1:0]     EN_MAGIC = 32'd4;
  localparam logic [DW-1:0]     BAUD_RST = 32'h0400_0000;
  localparam logic [ESRC_W-1:0] ESRC_BRK = '1;

  localparam logic [AW-1:0] A_START_RX = 5'd0;
  localparam logic [AW-1:0] A_STOP_RX  = 5'd1;
  localparam logic [AW-1:0] A_START_TX = 5'd2;
  localparam logic [AW-1:0] A_STOP_TX  = 5'd3;
  localparam logic [AW-1:0] A_SUSPEND  = 5'd4;
  localparam logic [AW-1:0] A_EV0      = 5'd5;
  localparam logic [AW-1:0] A_MASK     = 5'd9;
  localparam logic [AW-1:0] A_MASK_SET = 5'd10;
  localparam logic [AW-1:0] A_MASK_CLR = 5'd11;
  localparam logic [AW-1:0] A_ERRSRC   = 5'd12;
  localparam logic [AW-1:0] A_ENABLE   = 5'd13;
  localparam logic [AW-1:0] A_PIN0     = 5'd14;
  localparam logic [AW-1:0] A_BAUD     = 5'd18;
  localparam logic [AW-1:0] A_TXD      = 5'd19;

  function automatic logic irq_of(input logic [NEV-1:0] ev, input logic [NEV-1:0] msk);
    return |(ev & msk);
  endfunction

  function automatic logic [NEV-1:0] mask_next(input logic [NEV-1:0] cur, input logic ld,
                                               input logic set, input logic clr,
                                               input logic [NEV-1:0] v);
    logic [NEV-1:0] n;
    n = cur;
    if (ld)  n = v;
    if (set) n = n | v;
    if (clr) n = n & ~v;
    return n;
  endfunction

  function automatic logic [ESRC_W-1:0] esrc_next(input logic [ESRC_W-1:0] cur, input logic clr,
                                                  input logic [ESRC_W-1:0] v, input logic brk);
    logic [ESRC_W-1:0] n;
    n = clr ? (cur & ~v) : cur;
    if (brk) n = n | ESRC_BRK;
    return n;
  endfunction
endpackage

// File: rtl/uart_te_events.sv
module uart_te_events
  import uart_te_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] wr_hit,
  input  logic [DW-1:0]  wdata,
  input  logic [NEV-1:0] hw_set,
  input  logic [NEV-1:0] mask,
  output logic [NEV-1:0] ev,
  output logic           irq
);
  logic wzero;
  assign wzero = (wdata == '0);

  for (genvar i = 0; i < NEV; i++) begin : g_ev
    if (i == EV_RXRDY) begin : g_clear_only
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 ev[i] <= 1'b0;
        else if (hw_set[i])         ev[i] <= 1'b1;
        else if (wr_hit[i] && wzero) ev[i] <= 1'b0;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ev[i] <= 1'b0;
        else if (hw_set[i]) ev[i] <= 1'b1;
        else if (wr_hit[i]) ev[i] <= !wzero;
      end
    end
  end

  assign irq = irq_of(ev, mask);

  // R8: a hardware set always lands, whatever software writes alongside it
  p_hw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set[EV_RXRDY] |=> ev[EV_RXRDY]);
  // R8: a nonzero write never clears RX-ready
  p_rxrdy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[EV_RXRDY] && wr_hit[EV_RXRDY] && !wzero) |=> ev[EV_RXRDY]);
endmodule

// File: rtl/uart_te_tx.sv
module uart_te_tx
  import uart_te_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic              started,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              done
);
  logic pend_q;
  logic take;

  assign take = load_req && started && !pend_q;
  assign done = pend_q && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      tx_data <= '0;
    end else if (take) begin
      pend_q  <= 1'b1;
      tx_data <= byte_in;
    end else if (done) begin
      pend_q  <= 1'b0;
    end
  end

  assign tx_valid = pend_q;

  // R7: an offered byte stays put until the engine takes it
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R7: a write while busy does not disturb the byte on offer
  p_busy_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && tx_valid) |=> $stable(tx_data));
endmodule

// File: rtl/uart_te_cfg.sv
module uart_te_cfg
  import uart_te_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPIN-1:0]          pin_wr,
  input  logic                     baud_wr,
  input  logic [DW-1:0]            wdata,
  output logic [NPIN-1:0][DW-1:0]  pin_q,
  output logic [DW-1:0]            baud_q
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pin_q[i] <= '1;
      else if (pin_wr[i]) pin_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       baud_q <= BAUD_RST;
    else if (baud_wr) baud_q <= wdata;
  end
endmodule

// File: rtl/uart_taskevt_ctrl.sv
module uart_taskevt_ctrl
  import uart_te_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_got,
  input  logic              line_brk,
  output logic              rx_run,
  output logic              irq
);
  logic en_q, txs_q, rxs_q;
  logic [NEV-1:0]    mask_q;
  logic [ESRC_W-1:0] esrc_q;
  logic [NEV-1:0]    ev_q;

  // named write events
  logic wr_ok, w_one, w_zero;
  logic t_start_rx, t_stop_rx, t_start_tx, t_stop_tx, t_susp;
  logic en_on, en_off, halt_rx, halt_tx, tx_done;

  assign wr_ok  = bus_we && (en_q || bus_addr == A_ENABLE);
  assign w_one  = (bus_wdata == 32'd1);
  assign w_zero = (bus_wdata == '0);

  assign t_start_rx = wr_ok && bus_addr == A_START_RX && w_one;
  assign t_stop_rx  = wr_ok && bus_addr == A_STOP_RX  && w_one;
  assign t_start_tx = wr_ok && bus_addr == A_START_TX && w_one;
  assign t_stop_tx  = wr_ok && bus_addr == A_STOP_TX  && w_one;
  assign t_susp     = wr_ok && bus_addr == A_SUSPEND  && w_one;
  assign en_on      = wr_ok && bus_addr == A_ENABLE   && bus_wdata == EN_MAGIC;
  assign en_off     = wr_ok && bus_addr == A_ENABLE   && w_zero;
  assign halt_rx    = t_stop_rx || t_susp || en_off;
  assign halt_tx    = t_stop_tx || t_susp || en_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      txs_q <= 1'b0;
      rxs_q <= 1'b0;
    end else begin
      if (en_on)           en_q <= 1'b1;
      else if (en_off)     en_q <= 1'b0;
      if (t_start_tx)      txs_q <= 1'b1;
      else if (halt_tx)    txs_q <= 1'b0;
      if (t_start_rx)      rxs_q <= 1'b1;
      else if (halt_rx)    rxs_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      esrc_q <= '0;
    end else begin
      mask_q <= mask_next(mask_q, wr_ok && bus_addr == A_MASK,
                          wr_ok && bus_addr == A_MASK_SET,
                          wr_ok && bus_addr == A_MASK_CLR, bus_wdata[NEV-1:0]);
      esrc_q <= esrc_next(esrc_q, wr_ok && bus_addr == A_ERRSRC,
                          bus_wdata[ESRC_W-1:0], line_brk);
    end
  end

  logic [NEV-1:0] ev_wr, ev_hw;
  for (genvar i = 0; i < NEV; i++) begin : g_evdec
    assign ev_wr[i] = wr_ok && bus_addr == A_EV0 + AW'(i);
  end
  assign ev_hw[EV_RXRDY] = rx_got;
  assign ev_hw[EV_TXRDY] = tx_done;
  assign ev_hw[EV_ERR]   = line_brk;
  assign ev_hw[EV_RXTO]  = halt_rx;

  uart_te_events u_events (
    .clk(clk), .rst_n(rst_n), .wr_hit(ev_wr), .wdata(bus_wdata),
    .hw_set(ev_hw), .mask(mask_q), .ev(ev_q), .irq(irq)
  );

  uart_te_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load_req(wr_ok && bus_addr == A_TXD),
    .started(txs_q), .byte_in(bus_wdata[BYTE_W-1:0]), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .done(tx_done)
  );

  logic [NPIN-1:0]         pin_wr;
  logic [NPIN-1:0][DW-1:0] pin_q;
  logic [DW-1:0]           baud_q;
  for (genvar i = 0; i < NPIN; i++) begin : g_pindec
    assign pin_wr[i] = wr_ok && bus_addr == A_PIN0 + AW'(i);
  end

  uart_te_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .pin_wr(pin_wr), .baud_wr(wr_ok && bus_addr == A_BAUD),
    .wdata(bus_wdata), .pin_q(pin_q), .baud_q(baud_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (en_q) begin
      unique case (bus_addr)
        A_MASK, A_MASK_SET, A_MASK_CLR: bus_rdata = DW'(mask_q);
        A_ERRSRC:                       bus_rdata = DW'(esrc_q);
        A_ENABLE:                       bus_rdata = EN_MAGIC;
        A_BAUD:                         bus_rdata = baud_q;
        A_TXD:                          bus_rdata = DW'(tx_data);
        default: begin
          for (int i = 0; i < NEV; i++)
            if (bus_addr == A_EV0 + AW'(i)) bus_rdata = DW'(ev_q[i]);
          for (int i = 0; i < NPIN; i++)
            if (bus_addr == A_PIN0 + AW'(i)) bus_rdata = pin_q[i];
        end
      endcase
    end
  end

  assign rx_run = rxs_q;

  // R2: near-miss enable values change nothing
  p_magic_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_ENABLE && !w_zero && bus_wdata != EN_MAGIC) |=> $stable(en_q));
  // R3: writes elsewhere are dropped while disabled
  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && bus_we && bus_addr != A_ENABLE) |=> ($stable(mask_q) && $stable(txs_q) && $stable(rxs_q)));
  // R4: disable halts both directions and raises RX timeout
  p_off_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_off |=> (!en_q && !txs_q && !rxs_q && ev_q[EV_RXTO]));
  // R6: stop-RX raises the timeout and stops the receiver
  p_stoprx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    t_stop_rx |=> (!rxs_q && ev_q[EV_RXTO]));
  // R11: a break fills the error source and flags the error event
  p_break_r11: assert property (@(posedge clk) disable iff (!rst_n)
    line_brk |=> (esrc_q == ESRC_BRK && ev_q[EV_ERR]));
endmodule

// File: tb/uart_taskevt_ctrl_bench.sv
`timescale 1ns/1ps
module uart_taskevt_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_got = 1'b0, line_brk = 1'b0, rx_run, irq;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_taskevt_ctrl u_uart_taskevt_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_got(rx_got),
    .line_brk(line_brk), .rx_run(rx_run), .irq(irq)
  );

  // behavioural reference state
  bit        m_en, m_txs, m_rxs, m_pend;
  bit [7:0]  m_txd;
  bit [3:0]  m_ev, m_mask;
  bit [1:0]  m_es;
  bit [31:0] m_pin [4];
  bit [31:0] m_baud;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_txs = 0; m_rxs = 0; m_pend = 0; m_txd = 0;
      m_ev = 0; m_mask = 0; m_es = 0; m_baud = 32'h0400_0000;
      foreach (m_pin[k]) m_pin[k] = 32'hFFFF_FFFF;
    end else begin
      int a; bit [31:0] d; bit ok, done;
      a = bus_addr; d = bus_wdata;
      ok = bus_we && (m_en || a == 13);
      done = m_pend && tx_ready;
      if (ok) begin
        case (a)
          0: if (d == 1) m_rxs = 1;
          1: if (d == 1) begin m_rxs = 0; m_ev[3] = 1; end
          2: if (d == 1) m_txs = 1;
          3: if (d == 1) m_txs = 0;
          4: if (d == 1) begin m_txs = 0; m_rxs = 0; m_ev[3] = 1; end
          5: if (d == 0) m_ev[0] = 0;
          6, 7, 8: m_ev[a-5] = (d != 0);
          9:  m_mask = d[3:0];
          10: m_mask = m_mask | d[3:0];
          11: m_mask = m_mask & ~d[3:0];
          12: m_es = m_es & ~d[1:0];
          13: if (d == 4) m_en = 1;
              else if (d == 0) begin m_en = 0; m_txs = 0; m_rxs = 0; m_ev[3] = 1; end
          14, 15, 16, 17: m_pin[a-14] = d;
          18: m_baud = d;
          19: if (m_txs && !m_pend) begin m_txd = d[7:0]; m_pend = 1; end
          default: ;
        endcase
      end
      if (done) begin m_pend = 0; m_ev[1] = 1; end
      if (rx_got) m_ev[0] = 1;
      if (line_brk) begin m_es = 2'b11; m_ev[2] = 1; end
    end
  end

  function automatic bit [31:0] exp_rd(int a);
    if (!m_en) return 0;
    case (a)
      5, 6, 7, 8:     return {31'b0, m_ev[a-5]};
      9, 10, 11:      return {28'b0, m_mask};
      12:             return {30'b0, m_es};
      13:             return 32'd4;
      14, 15, 16, 17: return m_pin[a-14];
      18:             return m_baud;
      19:             return {24'b0, m_txd};
      default:        return 0;
    endcase
  endfunction

  function automatic string req_of(int a);
    if (!m_en) return "R3";
    if (a >= 5 && a <= 8) return "R8";
    if (a >= 9 && a <= 11) return "R9";
    if (a == 12) return "R11";
    if (a == 13) return "R2";
    if (a >= 14 && a <= 18) return "R1";
    if (a == 19) return "R7";
    return "R12";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R10 irq", 32'(irq), 32'(|(m_ev & m_mask)));
      chk("R7 tx_valid", 32'(tx_valid), 32'(m_pend));
      if (m_pend) chk("R7 tx_data", 32'(tx_data), 32'(m_txd));
      chk("R5 rx_run", 32'(rx_run), 32'(m_rxs));
      chk({req_of(bus_addr), " rdata"}, bus_rdata, exp_rd(bus_addr));
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic wr(int a, bit [31:0] d);
    bus_we = 1; bus_addr = 5'(a); bus_wdata = d; cyc(); bus_we = 0;
  endtask
  task automatic rd(int a, bit [31:0] exp, string tag);
    bus_addr = 5'(a); #0.5; chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog: actual running expected finished");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(); cyc(); rst_n = 1; cyc();
    chk("R1 reset irq", 32'(irq), 0);
    chk("R1 reset tx_valid", 32'(tx_valid), 0);
    rd(18, 0, "R3 disabled read");
    wr(13, 5);  rd(13, 0, "R2 near-miss 5");
    wr(13, 1);  rd(13, 0, "R2 near-miss 1");
    wr(18, 32'h123); wr(9, 4'hF);
    wr(13, 4);
    rd(18, 32'h0400_0000, "R1 baud reset / R3 write dropped");
    rd(16, 32'hFFFF_FFFF, "R1 pin reset");
    rd(9, 0, "R3 mask write dropped");
    rd(13, 4, "R2 enabled readback");
    rd(2, 0, "R12 task reads 0");
    rd(25, 0, "R12 unmapped read");
    wr(25, 32'hFFFF);
    // TX path
    wr(2, 2); wr(19, 8'h11);
    chk("R5 start-TX needs 1", 32'(tx_valid), 0);
    wr(2, 1); wr(19, 8'hA5);
    chk("R7 accepted", {23'b0, tx_valid, tx_data}, {23'b0, 1'b1, 8'hA5});
    wr(19, 8'h3C);
    chk("R7 busy reject", 32'(tx_data), 8'hA5);
    cyc(); cyc();
    chk("R7 held", 32'(tx_valid), 1);
    tx_ready = 1; cyc(); tx_ready = 0;
    chk("R7 handoff", 32'(tx_valid), 0);
    rd(6, 1, "R7 TX-ready event");
    // mask aliases
    wr(10, 4'h2);
    chk("R10 irq on TX-ready", 32'(irq), 1);
    rd(11, 2, "R9 clear alias reads mask");
    wr(11, 4'h2);
    chk("R10 irq masked", 32'(irq), 0);
    // RX-ready event
    rx_got = 1; cyc(); rx_got = 0;
    rd(5, 1, "R8 rx_got sets");
    wr(5, 1); rd(5, 1, "R8 nonzero ignored");
    wr(5, 0); rd(5, 0, "R8 zero clears");
    bus_we = 1; bus_addr = 5; bus_wdata = 0; rx_got = 1; cyc(); bus_we = 0; rx_got = 0;
    rd(5, 1, "R8 set wins over clear");
    // receiver
    wr(0, 3); chk("R5 start-RX needs 1", 32'(rx_run), 0);
    wr(0, 1); chk("R5 start-RX", 32'(rx_run), 1);
    wr(8, 0); wr(1, 1);
    chk("R6 stop-RX", 32'(rx_run), 0);
    rd(8, 1, "R6 RX timeout");
    // break / error source
    line_brk = 1; cyc(); line_brk = 0;
    rd(12, 3, "R11 break sets source");
    rd(7, 1, "R11 error event");
    wr(12, 1); rd(12, 2, "R11 w1c");
    wr(9, 4'h4); chk("R10 error irq", 32'(irq), 1);
    bus_we = 1; bus_addr = 12; bus_wdata = 3; line_brk = 1; cyc(); bus_we = 0; line_brk = 0;
    rd(12, 3, "R11 break wins over clear");
    // stop-TX, suspend
    wr(3, 1); wr(19, 8'h77);
    chk("R6 stop-TX", 32'(tx_valid), 0);
    wr(0, 1); wr(2, 1); wr(8, 0); wr(4, 1);
    chk("R6 suspend RX", 32'(rx_run), 0);
    rd(8, 1, "R6 suspend timeout");
    wr(19, 8'h55); chk("R6 suspend TX", 32'(tx_valid), 0);
    // disable
    wr(0, 1); wr(8, 0); wr(13, 0);
    chk("R4 disable stops RX", 32'(rx_run), 0);
    rd(8, 0, "R3 disabled event read");
    wr(13, 4); rd(8, 1, "R4 disable sets timeout");
    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = $urandom_range(0, 5);
      bus_we = ($urandom_range(0, 1) == 1);
      bus_addr = 5'($urandom_range(0, 21));
      case (sel)
        0: bus_wdata = 0; 1: bus_wdata = 1; 2: bus_wdata = 4;
        3: bus_wdata = 3; 4: bus_wdata = 2; default: bus_wdata = $urandom;
      endcase
      tx_ready = ($urandom_range(0, 2) == 0);
      rx_got   = ($urandom_range(0, 7) == 0);
      line_brk = ($urandom_range(0, 15) == 0);
      cyc();
    end
    bus_we = 0; rx_got = 0; line_brk = 0; tx_ready = 0;
    cyc();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule